// File: doc/BRIEF.md
# SPI Flash Page Program Engine

This block writes one page of a serial flash device. A host reaches it over a small 8-bit register bus. The bus has an address, write data, a write strobe, a read strobe and registered read data. The host first streams the payload bytes, one per write, into a single data-port address, and those bytes collect in an internal page buffer. It then loads the 24-bit target address, the program opcode and the length, given as the byte count minus one. Finally it starts the transfer by writing the mode/status register.

Once started, the engine drops chip select and shifts out a frame in SPI mode 0. The frame holds the opcode, the three address bytes and the buffered payload, and chip select then returns high. The same mode/status register reports whether the engine is running, whether the buffer is empty, and whether programming mode has been entered.

The register bus has no back-pressure: every access completes in one cycle. A data-port write is dropped when the buffer is full or a transfer is running.

Top module: `flash_page_writer`

## Requirements
- R1: After reset, cs_n is high, sclk is low, the mode/status register reads 0x10, the opcode register reads 0x02, the length register reads DEPTH-1 (0x7F), and the three address registers read 0x00.
- R2: The address registers are 0x64 (bits 23:16), 0x65 (bits 15:8) and 0x66 (bits 7:0). The opcode register is 0x6D. The length register is 0x71 and keeps only its low log2(DEPTH) bits, so writing 0xFF reads back 0x7F. Read data is valid in the cycle after the read strobe.
- R3: Each write to data port 0x70 appends one byte to the buffer in order. Once DEPTH bytes are held, further data-port writes are dropped.
- R4: Bit 7 of mode register 0x6F takes the value written to it and reads back the programming-mode state.
- R5: A write to 0x6F with bit 5 set starts a transfer only if the engine is idle, programming mode was already set before this write, and the buffer holds at least one byte. Otherwise cs_n stays high.
- R6: A transfer sends, MSB first in SPI mode 0 while cs_n is low, the opcode, then address bits 23:16, 15:8 and 7:0, then the payload bytes in buffer order.
- R7: The number of payload bytes sent is the smaller of (length register + 1) and the number of bytes buffered.
- R8: Bit 5 of 0x6F reads 1 while a transfer runs and 0 after it. Bit 4 reads 1 only when the engine is idle and the buffer is empty. A start empties the buffer, so any unsent bytes are discarded.
- R9: With an effective divide D (the parameter, clamped to at least 2 and rounded down to even) and n payload bytes, cs_n falls on the clock edge that takes the start write. It rises exactly (16*(4+n)+1)*D/2 cycles later.
- R10: Data-port writes made during a transfer are dropped.
- R11: sclk is low whenever cs_n is high, and mosi does not change while sclk is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 8 | Register bus address |
| reg_wdata | input | 8 | Register bus write data |
| reg_we | input | 1 | Write strobe, one access per cycle |
| reg_re | input | 1 | Read strobe |
| reg_rdata | output | 8 | Read data, registered, valid the cycle after reg_re |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_cs_n | output | 1 | Active-low chip select |

## Verification
Register reads are due one cycle after the strobe. The bench drives every access on a falling edge and samples read data on the next falling edge, after exactly one rising edge has passed. The start decision and chip select act on the same edge as the start write. So cs_n is checked low at the first falling edge after that write. A free-running cycle counter then measures the low period against the R9 formula to the exact cycle. Serial bits are captured at falling clock edges whenever sclk has just risen, which keeps the capture clear of the edge where mosi shifts.

// File: rtl/fpw_pkg.sv
package fpw_pkg;
  localparam logic [7:0] REG_ADDR_HI  = 8'h64;
  localparam logic [7:0] REG_ADDR_MID = 8'h65;
  localparam logic [7:0] REG_ADDR_LO  = 8'h66;
  localparam logic [7:0] REG_OPCODE   = 8'h6D;
  localparam logic [7:0] REG_MODE     = 8'h6F;
  localparam logic [7:0] REG_DATA     = 8'h70;
  localparam logic [7:0] REG_LEN      = 8'h71;

  localparam int MODE_ISP_BIT   = 7;
  localparam int MODE_BUSY_BIT  = 5;
  localparam int MODE_EMPTY_BIT = 4;

  localparam logic [7:0] OPCODE_DEFAULT = 8'h02;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_SHIFT,
    SEQ_TAIL
  } seq_state_e;

  typedef struct packed {
    logic [7:0] hi;
    logic [7:0] mid;
    logic [7:0] lo;
  } flash_addr_t;
endpackage

// File: rtl/fpw_regs.sv
module fpw_regs
  import fpw_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int LW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    reg_addr,
  input  logic [7:0]    reg_wdata,
  input  logic          reg_we,
  input  logic          reg_re,
  output logic [7:0]    reg_rdata,
  input  logic          busy,
  input  logic [CW-1:0] buf_count,
  output flash_addr_t   flash_addr,
  output logic [7:0]    opcode,
  output logic [LW-1:0] len_m1,
  output logic          push,
  output logic          start
);
  logic       isp_q;
  logic       wr_mode;
  logic       buf_empty;
  logic [7:0] status;

  assign wr_mode   = reg_we && (reg_addr == REG_MODE);
  assign buf_empty = (buf_count == '0) && !busy;
  assign start     = wr_mode && reg_wdata[MODE_BUSY_BIT] && isp_q
                     && (buf_count != '0) && !busy;
  assign push      = reg_we && (reg_addr == REG_DATA) && !busy;

  always_comb begin
    status                 = 8'h00;
    status[MODE_ISP_BIT]   = isp_q;
    status[MODE_BUSY_BIT]  = busy;
    status[MODE_EMPTY_BIT] = buf_empty;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flash_addr <= '0;
      opcode     <= OPCODE_DEFAULT;
      len_m1     <= LW'(DEPTH - 1);
      isp_q      <= 1'b0;
    end else if (reg_we) begin
      case (reg_addr)
        REG_ADDR_HI:  flash_addr.hi  <= reg_wdata;
        REG_ADDR_MID: flash_addr.mid <= reg_wdata;
        REG_ADDR_LO:  flash_addr.lo  <= reg_wdata;
        REG_OPCODE:   opcode         <= reg_wdata;
        REG_LEN:      len_m1         <= reg_wdata[LW-1:0];
        REG_MODE:     isp_q          <= reg_wdata[MODE_ISP_BIT];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata <= 8'h00;
    end else if (reg_re) begin
      case (reg_addr)
        REG_ADDR_HI:  reg_rdata <= flash_addr.hi;
        REG_ADDR_MID: reg_rdata <= flash_addr.mid;
        REG_ADDR_LO:  reg_rdata <= flash_addr.lo;
        REG_OPCODE:   reg_rdata <= opcode;
        REG_LEN:      reg_rdata <= 8'(len_m1);
        REG_MODE:     reg_rdata <= status;
        default:      reg_rdata <= 8'h00;
      endcase
    end
  end

  // an accepted start always launches the sequencer on the next cycle
  assert_start_launches_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
endmodule

// File: rtl/fpw_buffer.sv
module fpw_buffer #(
  parameter int DEPTH = 128,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [7:0]    din,
  input  logic          clear,
  input  logic [AW-1:0] rd_idx,
  output logic [7:0]    rd_data,
  output logic [CW-1:0] count
);
  logic [7:0] mem [DEPTH];
  logic       full;
  logic       do_push;

  assign full    = (count == CW'(DEPTH));
  assign do_push = push && !full && !clear;
  assign rd_data = mem[rd_idx];

  always_ff @(posedge clk) begin
    if (do_push) mem[count[AW-1:0]] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count <= '0;
    else if (clear)   count <= '0;
    else if (do_push) count <= count + CW'(1);
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
endmodule

// File: rtl/fpw_spi_seq.sv
module fpw_spi_seq
  import fpw_pkg::*;
#(
  parameter int DEPTH   = 128,
  parameter int CLK_DIV = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1),
  localparam int IW = CW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [7:0]    opcode,
  input  flash_addr_t   faddr,
  input  logic [CW-1:0] nbytes,
  output logic [AW-1:0] rd_idx,
  input  logic [7:0]    rd_byte,
  output logic          sclk,
  output logic          mosi,
  output logic          cs_n,
  output logic          busy
);
  localparam int EFF_DIV = (CLK_DIV < 2) ? 2 : CLK_DIV;
  localparam int HALF    = EFF_DIV / 2;
  localparam int HW      = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [HW-1:0] HALF_M1 = HW'(HALF - 1);

  seq_state_e  st;
  logic [HW-1:0] divc;
  logic [7:0]  sh;
  logic [2:0]  bitc;
  logic [IW-1:0] idx;
  logic [IW-1:0] last_idx;
  logic [IW-1:0] nxt;
  logic [7:0]  nb;
  flash_addr_t addr_q;
  logic        tick;

  assign tick = (divc == HALF_M1);
  assign busy = (st != SEQ_IDLE);
  assign mosi = sh[7];

  always_comb begin
    nxt    = idx + IW'(1);
    rd_idx = AW'(nxt - IW'(4));
    case (nxt)
      IW'(1):  nb = addr_q.hi;
      IW'(2):  nb = addr_q.mid;
      IW'(3):  nb = addr_q.lo;
      default: nb = rd_byte;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= SEQ_IDLE;
      divc     <= '0;
      sh       <= 8'h00;
      bitc     <= 3'd0;
      idx      <= '0;
      last_idx <= '0;
      addr_q   <= '0;
      sclk     <= 1'b0;
      cs_n     <= 1'b1;
    end else begin
      case (st)
        SEQ_IDLE: begin
          if (start) begin
            st       <= SEQ_SHIFT;
            cs_n     <= 1'b0;
            sclk     <= 1'b0;
            sh       <= opcode;
            bitc     <= 3'd7;
            idx      <= '0;
            last_idx <= IW'(nbytes) + IW'(3);
            addr_q   <= faddr;
            divc     <= '0;
          end
        end
        SEQ_SHIFT: begin
          if (tick) begin
            divc <= '0;
            if (!sclk) begin
              sclk <= 1'b1;
            end else begin
              sclk <= 1'b0;
              if (bitc == 3'd0) begin
                if (idx == last_idx) begin
                  st <= SEQ_TAIL;
                end else begin
                  idx  <= nxt;
                  sh   <= nb;
                  bitc <= 3'd7;
                end
              end else begin
                sh   <= {sh[6:0], 1'b0};
                bitc <= bitc - 3'd1;
              end
            end
          end else begin
            divc <= divc + HW'(1);
          end
        end
        SEQ_TAIL: begin
          if (tick) begin
            divc <= '0;
            cs_n <= 1'b1;
            st   <= SEQ_IDLE;
          end else begin
            divc <= divc + HW'(1);
          end
        end
        default: st <= SEQ_IDLE;
      endcase
    end
  end

  assert_idle_clock_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  assert_mosi_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));

  assert_select_only_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> busy);
endmodule

// File: rtl/flash_page_writer.sv
module flash_page_writer
  import fpw_pkg::*;
#(
  parameter int DEPTH   = 128,
  parameter int CLK_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] reg_addr,
  input  logic [7:0] reg_wdata,
  input  logic       reg_we,
  input  logic       reg_re,
  output logic [7:0] reg_rdata,
  output logic       spi_sclk,
  output logic       spi_mosi,
  output logic       spi_cs_n
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic          busy;
  logic          push;
  logic          start;
  logic [CW-1:0] buf_count;
  logic [AW-1:0] rd_idx;
  logic [7:0]    rd_byte;
  logic [7:0]    opcode;
  logic [LW-1:0] len_m1;
  flash_addr_t   flash_addr;
  logic [CW-1:0] len_p1;
  logic [CW-1:0] nbytes;

  assign len_p1 = CW'(len_m1) + CW'(1);
  assign nbytes = (len_p1 < buf_count) ? len_p1 : buf_count;

  fpw_regs #(.DEPTH(DEPTH)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_we     (reg_we),
    .reg_re     (reg_re),
    .reg_rdata  (reg_rdata),
    .busy       (busy),
    .buf_count  (buf_count),
    .flash_addr (flash_addr),
    .opcode     (opcode),
    .len_m1     (len_m1),
    .push       (push),
    .start      (start)
  );

  fpw_buffer #(.DEPTH(DEPTH)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (push),
    .din     (reg_wdata),
    .clear   (start),
    .rd_idx  (rd_idx),
    .rd_data (rd_byte),
    .count   (buf_count)
  );

  fpw_spi_seq #(.DEPTH(DEPTH), .CLK_DIV(CLK_DIV)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .opcode  (opcode),
    .faddr   (flash_addr),
    .nbytes  (nbytes),
    .rd_idx  (rd_idx),
    .rd_byte (rd_byte),
    .sclk    (spi_sclk),
    .mosi    (spi_mosi),
    .cs_n    (spi_cs_n),
    .busy    (busy)
  );

  // a launched transfer finds the buffer already emptied
  assert_clear_on_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (buf_count == '0));
endmodule

// File: tb/flash_page_writer_tb.sv
module flash_page_writer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 128;
  localparam int CLK_DIV    = 4;
  localparam int HALF       = CLK_DIV / 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] reg_addr = 8'h00;
  logic [7:0] reg_wdata = 8'h00;
  logic       reg_we = 1'b0;
  logic       reg_re = 1'b0;
  logic [7:0] reg_rdata;
  logic       spi_sclk, spi_mosi, spi_cs_n;

  int nchecks = 0;
  int nerr = 0;
  int cyc_cnt = 0;
  int ncap = 0;
  int nbit = 0;
  int viol = 0;
  logic [7:0] shin = 8'h00;
  logic [7:0] cap [140];
  logic [7:0] exp_b [140];
  logic prev_sclk = 1'b0;
  logic prev_mosi = 1'b0;
  bit   done_flag = 1'b0;

  flash_page_writer #(.DEPTH(DEPTH), .CLK_DIV(CLK_DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

  // serial monitor, sampled on falling clock edges
  always @(negedge clk) begin
    if (!spi_cs_n && spi_sclk && !prev_sclk) begin
      shin = {shin[6:0], spi_mosi};
      nbit++;
      if (nbit == 8) begin
        if (ncap < 140) cap[ncap] = shin;
        ncap++;
        nbit = 0;
      end
    end
    if (spi_sclk && prev_sclk && (spi_mosi !== prev_mosi)) viol++;
    if (spi_cs_n && spi_sclk) viol++;
    prev_sclk = spi_sclk;
    prev_mosi = spi_mosi;
  end

  task automatic check(input string req, input int act, input int expv);
    nchecks++;
    if (act != expv) begin
      nerr++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_re = 1'b1;
    @(negedge clk);
    reg_re = 1'b0;
    d = reg_rdata;
  endtask

  task automatic set_frame_head(input logic [7:0] op, input logic [7:0] h,
                                input logic [7:0] m, input logic [7:0] l);
    exp_b[0] = op; exp_b[1] = h; exp_b[2] = m; exp_b[3] = l;
  endtask

  task automatic run_xfer(input string tag, input int n, input bit push_during);
    logic [7:0] d;
    int t0;
    int guard;
    ncap = 0; nbit = 0;
    wr(8'h6F, 8'hA0);
    t0 = cyc_cnt;
    check({tag, " R5 cs_n low after start"}, int'(spi_cs_n), 0);
    rd(8'h6F, d);
    check({tag, " R8 status while busy"}, int'(d), 8'hA0);
    if (push_during) wr(8'h70, 8'hEE);
    guard = 0;
    while (spi_cs_n === 1'b0 && guard < 100000) begin
      @(negedge clk);
      guard++;
    end
    check({tag, " R9 cs_n low cycles"}, cyc_cnt - t0, (16 * (4 + n) + 1) * HALF);
    check({tag, " R7 bytes framed"}, ncap, 4 + n);
    for (int k = 0; k < 4 + n && k < 140; k++)
      check($sformatf("%s R6 byte %0d", tag, k), int'(cap[k]), int'(exp_b[k]));
    rd(8'h6F, d);
    check({tag, " R8 R10 status after"}, int'(d), 8'h90);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1 cs_n", int'(spi_cs_n), 1);
    check("R1 sclk", int'(spi_sclk), 0);
    rd(8'h6F, d); check("R1 status", int'(d), 8'h10);
    rd(8'h6D, d); check("R1 opcode", int'(d), 8'h02);
    rd(8'h71, d); check("R1 length", int'(d), 8'h7F);
    rd(8'h64, d); check("R1 addr hi", int'(d), 0);
    rd(8'h65, d); check("R1 addr mid", int'(d), 0);
    rd(8'h66, d); check("R1 addr lo", int'(d), 0);
  endtask

  task automatic t_regs();
    logic [7:0] d;
    wr(8'h64, 8'h12); wr(8'h65, 8'h34); wr(8'h66, 8'h56);
    rd(8'h64, d); check("R2 addr hi", int'(d), 8'h12);
    rd(8'h65, d); check("R2 addr mid", int'(d), 8'h34);
    rd(8'h66, d); check("R2 addr lo", int'(d), 8'h56);
    wr(8'h71, 8'hFF);
    rd(8'h71, d); check("R2 length masked", int'(d), 8'h7F);
  endtask

  task automatic t_no_isp();
    logic [7:0] d;
    wr(8'h70, 8'hAA); wr(8'h70, 8'hBB);
    wr(8'h6F, 8'h20);
    repeat (20) begin
      @(negedge clk);
      if (spi_cs_n !== 1'b1) check("R5 start without mode", 0, 1);
    end
    check("R5 idle without mode", int'(spi_cs_n), 1);
    rd(8'h6F, d); check("R5 status no mode", int'(d), 8'h00);
    wr(8'h6F, 8'h80);
    rd(8'h6F, d); check("R4 mode readback", int'(d), 8'h80);
  endtask

  task automatic t_basic();
    wr(8'h70, 8'hCC);
    wr(8'h71, 8'h02);
    set_frame_head(8'h02, 8'h12, 8'h34, 8'h56);
    exp_b[4] = 8'hAA; exp_b[5] = 8'hBB; exp_b[6] = 8'hCC;
    run_xfer("basic R3", 3, 1'b1);
  endtask

  task automatic t_short();
    wr(8'h70, 8'h11); wr(8'h70, 8'h22); wr(8'h70, 8'h33);
    wr(8'h70, 8'h44); wr(8'h70, 8'h55);
    wr(8'h71, 8'h01);
    set_frame_head(8'h02, 8'h12, 8'h34, 8'h56);
    exp_b[4] = 8'h11; exp_b[5] = 8'h22;
    run_xfer("short R10", 2, 1'b0);
  endtask

  task automatic t_empty_start();
    logic [7:0] d;
    wr(8'h6F, 8'hA0);
    repeat (20) begin
      @(negedge clk);
      if (spi_cs_n !== 1'b1) check("R5 start on empty buffer", 0, 1);
    end
    check("R5 empty start ignored", int'(spi_cs_n), 1);
    rd(8'h6F, d); check("R5 status empty start", int'(d), 8'h90);
  endtask

  task automatic t_opcode();
    logic [7:0] d;
    wr(8'h6D, 8'hAB);
    rd(8'h6D, d); check("R2 opcode readback", int'(d), 8'hAB);
    wr(8'h64, 8'h00); wr(8'h65, 8'hFF); wr(8'h66, 8'h01);
    wr(8'h70, 8'h5A);
    wr(8'h71, 8'h7F);
    set_frame_head(8'hAB, 8'h00, 8'hFF, 8'h01);
    exp_b[4] = 8'h5A;
    run_xfer("min R7", 1, 1'b0);
  endtask

  task automatic t_overflow();
    wr(8'h6D, 8'h02);
    for (int i = 0; i <= DEPTH; i++) wr(8'h70, 8'(i) ^ 8'h3C);
    wr(8'h71, 8'h7F);
    set_frame_head(8'h02, 8'h00, 8'hFF, 8'h01);
    for (int i = 0; i < DEPTH; i++) exp_b[4 + i] = 8'(i) ^ 8'h3C;
    run_xfer("full R3", DEPTH, 1'b0);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("Result: errors=%0d of %0d checks", nerr, nchecks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchecks++;
    nerr++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_no_isp();
    t_basic();
    t_short();
    t_empty_start();
    t_opcode();
    t_overflow();
    check("R11 serial line rules", viol, 0);
    finish_run();
  end
endmodule